// File: doc/BRIEF.md
# Frequency-Tracking Beep Tone Generator

This block makes a square-wave beep by picking one bit of a free-running counter. The counter advances once every two system clocks. Software writes two registers through a simple write port. One is a control register with an enable bit. The other is a 32-bit tap register whose field at bits 18:10 chooses the counter bit, and that field must be one-hot.

The clock feeding the block may be slowed to one half or one thirty-second of its full rate. A frequency-mode input tells the block which rate is in force. The block then uses a lower counter bit, so the tone keeps the same real-time pitch. With counter bit 10 tapped at full rate, the output period is 4096 system clocks.

The output is gated low whenever the tone is disabled or the tap field is not exactly one-hot. Register writes change the tone on the clock edge that performs them, and they never disturb the counter.

Top module: `beep_tone_gen`

## Requirements
- R1: After reset the enable bit and the tap field are zero, the counter is zero and `beep_o` is low.
- R2: The counter starts at zero when reset is released. It advances by one on every second rising edge, the first advance being on the second edge. With tap field bit 0 at full rate, `beep_o` first rises at edge 2048 after reset release.
- R3: A write with `wr_addr` = 0 loads the enable from `wr_data[0]`; all other data bits are ignored. While the enable is 0, `beep_o` is low.
- R4: A write with `wr_addr` = 1 loads the tap field from `wr_data[18:10]`; all other data bits are ignored. At full rate (`freq_mode` = 2'b00), field bit j selects counter bit 10+j.
- R5: If the tap field has no bit set, or more than one bit set, `beep_o` is low.
- R6: With `freq_mode` = 2'b01 (half rate), field bit j selects counter bit 9+j.
- R7: With `freq_mode` = 2'b10 (1/32 rate), field bit j selects counter bit 5+j. The code 2'b11 behaves as full rate.
- R8: A register write affects `beep_o` from the clock edge that captures it. It does not reset or disturb the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control register, 1 selects the tap register |
| wr_data | input | 32 | Write data |
| freq_mode | input | 2 | Clock rate: 00 full, 01 half, 10 one thirty-second, 11 full |
| beep_o | output | 1 | Square-wave tone output |

## Verification
The counter cannot be seen at the ports. Its phase can only be inferred through `beep_o`, so showing that a register write leaves the counter untouched is the hardest case to reach.

The bench keeps its own count of clock edges since reset release. Every comparison window derives the expected tap value from that one continuous count, so any restart or skip of the counter shows up as a mismatch. Taps are switched in mid-run, including low taps in the 1/32 mode that toggle every 64 clocks. The exact first rising edge at edge 2048 is checked separately.

// File: rtl/beep_pkg.sv
package beep_pkg;

   // Clock-rate codes driven on freq_mode
   typedef enum logic [1:0] {
      FM_FULL = 2'b00,
      FM_HALF = 2'b01,
      FM_SLOW = 2'b10,
      FM_RSVD = 2'b11
   } fmode_e;

   // Register select values on wr_addr
   localparam logic ADDR_CTL = 1'b0;
   localparam logic ADDR_TAP = 1'b1;

endpackage

// File: rtl/beep_half_counter.sv
module beep_half_counter #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt_o
);

   logic             phase_q;
   logic [CNT_W-1:0] cnt_q;

   // Half-rate advance: the count moves on every second edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         phase_q <= ~phase_q;
         if (phase_q) cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/beep_ctl_regs.sv
module beep_ctl_regs
   import beep_pkg::*;
#(
   parameter int REG_W  = 32,
   parameter int SEL_LO = 10,
   parameter int SEL_HI = 18
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     wr_addr,
   input  logic [REG_W-1:0]         wr_data,
   output logic                     en_o,
   output logic [SEL_HI-SEL_LO:0]   tap_o
);

   localparam int NSEL = SEL_HI - SEL_LO + 1;

   logic            en_q;
   logic [NSEL-1:0] tap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         tap_q <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_CTL) en_q  <= wr_data[0];
         else                     tap_q <= wr_data[SEL_HI:SEL_LO];
      end
   end

   // Reserved data bits are dropped on purpose
   logic unused_rsv;
   assign unused_rsv = ^{wr_data[REG_W-1:SEL_HI+1], wr_data[SEL_LO-1:1]};

   assign en_o  = en_q;
   assign tap_o = tap_q;

endmodule

// File: rtl/beep_tap_select.sv
module beep_tap_select
   import beep_pkg::*;
#(
   parameter int SEL_LO     = 10,
   parameter int SEL_HI     = 18,
   parameter int HALF_SHIFT = 1,
   parameter int SLOW_SHIFT = 5
) (
   input  logic [SEL_HI:SEL_LO-SLOW_SHIFT] cnt_i,
   input  logic [SEL_HI-SEL_LO:0]          tap_i,
   input  logic [1:0]                      freq_mode,
   output logic                            tap_bit_o,
   output logic                            tap_ok_o
);

   localparam int NSEL = SEL_HI - SEL_LO + 1;

   logic [NSEL-1:0] hit;

   for (genvar j = 0; j < NSEL; j++) begin : g_tap
      localparam int BF = SEL_LO + j;
      localparam int BH = BF - HALF_SHIFT;
      localparam int BS = BF - SLOW_SHIFT;
      logic cand;
      always_comb begin
         case (fmode_e'(freq_mode))
            FM_HALF: cand = cnt_i[BH];
            FM_SLOW: cand = cnt_i[BS];
            default: cand = cnt_i[BF];
         endcase
      end
      assign hit[j] = tap_i[j] & cand;
   end

   assign tap_bit_o = |hit;
   assign tap_ok_o  = $onehot(tap_i);

endmodule

// File: rtl/beep_tone_gen.sv
module beep_tone_gen
   import beep_pkg::*;
#(
   parameter int REG_W      = 32,
   parameter int CNT_W      = 20,
   parameter int SEL_LO     = 10,
   parameter int SEL_HI     = 18,
   parameter int HALF_SHIFT = 1,
   parameter int SLOW_SHIFT = 5,
   parameter bit OUT_REG    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [REG_W-1:0] wr_data,
   input  logic [1:0]       freq_mode,
   output logic             beep_o
);

   localparam int NSEL   = SEL_HI - SEL_LO + 1;
   localparam int LOW_BT = SEL_LO - SLOW_SHIFT;

   // Elaboration checks on the parameter set
   if (SEL_HI >= CNT_W)           begin : g_chk_cnt  $error("counter narrower than tap field"); end
   if (SEL_HI + 1 >= REG_W)       begin : g_chk_reg  $error("tap field does not fit register"); end
   if (LOW_BT < 0)                begin : g_chk_low  $error("slow shift exceeds field base"); end
   if (HALF_SHIFT > SLOW_SHIFT)   begin : g_chk_ord  $error("half shift above slow shift"); end
   if (SEL_LO < 2)                begin : g_chk_base $error("field base overlaps enable bit"); end

   logic             en_q;
   logic [NSEL-1:0]  tap_q;
   logic [CNT_W-1:0] cnt_q;
   logic             tap_bit;
   logic             tap_ok;
   logic             beep_raw;

   beep_ctl_regs #(
      .REG_W (REG_W),
      .SEL_LO(SEL_LO),
      .SEL_HI(SEL_HI)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .en_o   (en_q),
      .tap_o  (tap_q)
   );

   beep_half_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .cnt_o(cnt_q)
   );

   beep_tap_select #(
      .SEL_LO    (SEL_LO),
      .SEL_HI    (SEL_HI),
      .HALF_SHIFT(HALF_SHIFT),
      .SLOW_SHIFT(SLOW_SHIFT)
   ) u_sel (
      .cnt_i    (cnt_q[SEL_HI:LOW_BT]),
      .tap_i    (tap_q),
      .freq_mode(freq_mode),
      .tap_bit_o(tap_bit),
      .tap_ok_o (tap_ok)
   );

   assign beep_raw = en_q & tap_ok & tap_bit;

   if (OUT_REG) begin : g_oreg
      logic beep_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) beep_q <= 1'b0;
         else        beep_q <= beep_raw;
      end
      assign beep_o = beep_q;
   end else begin : g_ocomb
      assign beep_o = beep_raw;
   end

endmodule

// File: rtl/beep_tone_gen_chk.sv
module beep_tone_gen_chk #(
   parameter int CNT_W      = 20,
   parameter int SEL_LO     = 10,
   parameter int SEL_HI     = 18,
   parameter int HALF_SHIFT = 1,
   parameter int SLOW_SHIFT = 5,
   parameter bit OUT_REG    = 1'b0
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   wr_en,
   input logic                   wr_addr,
   input logic [SEL_HI-SEL_LO:0] wr_tap,
   input logic [1:0]             freq_mode,
   input logic                   en_q,
   input logic [SEL_HI-SEL_LO:0] tap_q,
   input logic [CNT_W-1:0]       cnt_q,
   input logic                   beep_o
);

   localparam int NSEL = SEL_HI - SEL_LO + 1;

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));

   // R2
   cnt_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != $past(cnt_q)) |=> (cnt_q == $past(cnt_q)));

   // R8
   tap_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr) |=> (tap_q == $past(wr_tap)));

   if (OUT_REG == 1'b0) begin : g_comb_chk
      // R3
      beep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !en_q |-> !beep_o);

      // R5
      tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($countones(tap_q) != 1) |-> !beep_o);

      // R6
      half_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (freq_mode == 2'b01 && en_q && tap_q == NSEL'(1)) |-> (beep_o == cnt_q[SEL_LO-HALF_SHIFT]));

      // R7
      slow_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (freq_mode == 2'b10 && en_q && tap_q == NSEL'(1)) |-> (beep_o == cnt_q[SEL_LO-SLOW_SHIFT]));
   end

endmodule

bind beep_tone_gen beep_tone_gen_chk #(
   .CNT_W     (CNT_W),
   .SEL_LO    (SEL_LO),
   .SEL_HI    (SEL_HI),
   .HALF_SHIFT(HALF_SHIFT),
   .SLOW_SHIFT(SLOW_SHIFT),
   .OUT_REG   (OUT_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_tap   (wr_data[SEL_HI:SEL_LO]),
   .freq_mode(freq_mode),
   .en_q     (en_q),
   .tap_q    (tap_q),
   .cnt_q    (cnt_q),
   .beep_o   (beep_o)
);

// File: tb/tb_beep_tone_gen.sv
`timescale 1ns/1ps
module tb_beep_tone_gen;

   localparam int NSEL = 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_addr = 1'b0;
   logic [31:0] wr_data = '0;
   logic [1:0]  freq_mode = 2'b00;
   logic        beep_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Bench-side model state
   logic [31:0]     ec;
   logic            m_en = 1'b0;
   logic [NSEL-1:0] m_tap = '0;

   always #2 clk = ~clk;

   beep_tone_gen dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .freq_mode(freq_mode),
      .beep_o   (beep_o)
   );

   // Edges since reset release; counter value is ec/2
   always @(posedge clk) begin
      if (!rst_n) ec <= '0;
      else        ec <= ec + 32'd1;
   end

   function automatic logic exp_beep();
      int pos = 0;
      int n = 0;
      int sh;
      if (!m_en) return 1'b0;
      for (int j = 0; j < NSEL; j++) if (m_tap[j]) begin n++; pos = j; end
      if (n != 1) return 1'b0;
      case (freq_mode)
         2'b01:   sh = 1;
         2'b10:   sh = 5;
         default: sh = 0;
      endcase
      return ec[10 + pos - sh + 1];
   endfunction

   task automatic check1(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at edge %0d", tag, act, exp, ec);
      end
   endtask

   task automatic compare_window(input int n, input string tag);
      int bad = 0;
      logic a0 = 1'b0;
      logic e0 = 1'b0;
      int at = 0;
      repeat (n) begin
         @(negedge clk);
         if (beep_o !== exp_beep()) begin
            if (bad == 0) begin a0 = beep_o; e0 = exp_beep(); at = ec; end
            bad++;
         end
      end
      checks++;
      if (bad != 0) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at edge %0d (%0d bad samples)", tag, a0, e0, at, bad);
      end
   endtask

   task automatic do_write(input logic a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      if (a == 1'b0) m_en = d[0];
      else           m_tap = d[18:10];
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      m_en = 1'b0; m_tap = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // R1
   task automatic t_reset_state();
      do_reset();
      freq_mode = 2'b00;
      check1("R1 beep low after reset", beep_o, 1'b0);
      compare_window(40, "R1 idle after reset");
   endtask

   // R2
   task automatic t_first_edge();
      do_reset();
      freq_mode = 2'b00;
      do_write(1'b0, 32'h1);
      do_write(1'b1, 32'h400);
      while (ec != 32'd2047) @(negedge clk);
      check1("R2 before first rise", beep_o, 1'b0);
      @(negedge clk);
      check1("R2 first rise at edge 2048", beep_o, 1'b1);
      compare_window(2200, "R2 full period tap10");
   endtask

   // R4
   task automatic t_full_taps();
      freq_mode = 2'b00;
      do_write(1'b1, 32'h800);
      compare_window(4500, "R4 tap field bit1");
      do_write(1'b1, 32'h2000);
      compare_window(4500, "R4 tap field bit3");
      do_write(1'b1, 32'h8000_0401);
      compare_window(3000, "R4 reserved tap bits ignored");
   endtask

   // R3
   task automatic t_enable();
      do_write(1'b0, 32'hFFFF_FFFE);
      compare_window(3000, "R3 enable cleared with reserved ones");
      do_write(1'b0, 32'h8000_0001);
      compare_window(3000, "R3 enable set");
   endtask

   // R5
   task automatic t_bad_taps();
      do_write(1'b1, 32'h0);
      compare_window(3000, "R5 no tap bit");
      do_write(1'b1, 32'h0000_0C00);
      compare_window(3000, "R5 two tap bits");
      do_write(1'b1, 32'h0007_FC00);
      compare_window(3000, "R5 all tap bits");
   endtask

   // R6, R7
   task automatic t_modes();
      do_write(1'b1, 32'h400);
      @(negedge clk); freq_mode = 2'b01;
      compare_window(2500, "R6 half rate tap");
      do_write(1'b1, 32'h1000);
      compare_window(4500, "R6 half rate field bit2");
      @(negedge clk); freq_mode = 2'b10;
      do_write(1'b1, 32'h400);
      compare_window(600, "R7 slow rate tap");
      do_write(1'b1, 32'h4000);
      compare_window(2500, "R7 slow rate field bit4");
      @(negedge clk); freq_mode = 2'b11;
      compare_window(4500, "R7 code 11 acts as full");
      @(negedge clk); freq_mode = 2'b00;
   endtask

   // R8
   task automatic t_live_switch();
      @(negedge clk); freq_mode = 2'b10;
      for (int k = 0; k < 4; k++) begin
         do_write(1'b1, 32'h400 << k);
         compare_window(300, "R8 switch keeps counter phase");
         do_write(1'b0, 32'h0);
         compare_window(50, "R8 disable takes effect");
         do_write(1'b0, 32'h1);
      end
      @(negedge clk); freq_mode = 2'b00;
      compare_window(3000, "R8 counter continuous after writes");
   endtask

   initial begin
      t_reset_state();
      t_first_edge();
      t_full_taps();
      t_enable();
      t_bad_taps();
      t_modes();
      t_live_switch();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule